// File: doc/BRIEF.md
# Dual Weekday Alarm Comparator

This block watches a running calendar clock and raises an interrupt when the time reaches one of two alarm settings. Alarm A and alarm B each hold three host-loaded values: a minute in BCD, an hour in BCD, and a seven-bit weekday mask. The mask lets an alarm fire every day, on one chosen day, or on any chosen set of days. The timekeeping counters sit outside the block. They supply the current minute, hour and weekday, together with a one-cycle strobe at each minute rollover. The alarms are compared only on that strobe, so a single matching minute sets a flag exactly once.

Each alarm has its own enable bit and its own sticky flag. The host can poll the flag. Once set, a flag holds its interrupt asserted until the host clears it or disables the alarm. A two-bit routing field steers four sources onto two active-low, wired-AND interrupt pins: alarm A, alarm B, an external periodic interrupt and a 32 kHz clock. An oscillator-halt input, raised by the timekeeper after a cold start, forces the enables, the flags and the routing back to their default state. It leaves the stored alarm times untouched.

Top module: `alm_dual_cmp`

## Requirements
- R1: After reset both flags are 0, both enables are 0, the routing field is 00, and with the periodic input high and the clock input high both pins are high.
- R2: Register map, on a write strobe with address and byte: address 0/1/2 hold alarm A minute (bits 6:0), hour (bits 5:0) and weekday mask (bits 6:0). Addresses 3/4/5 hold the same for alarm B. Address 6 is the control byte: bit 0 enables A, bit 1 enables B, bit 2 is A's flag, bit 3 is B's flag, bits 5:4 are the routing field.
- R3: An alarm's flag is set in the cycle after a minute strobe in which the alarm is enabled, its minute and hour equal the current minute and hour, and the mask bit selected by the current weekday is 1.
- R4: Weekday values 0 to 6 select mask bits 0 to 6. A cleared mask bit, or weekday value 7, never produces a match.
- R5: Without a minute strobe no flag is set, even when the current time equals an alarm.
- R6: A set flag stays set until a control write carries 0 in that flag's bit. A control write carrying 1 there leaves the flag unchanged.
- R7: A control write that clears an alarm's enable clears its flag in the same cycle, and that alarm then ignores matches.
- R8: When a match and a control write that clears the same flag land in one cycle, the flag ends set. When the write also disables that alarm, the flag ends clear.
- R9: Routing: alarm A always drives pin A and the 32 kHz clock always drives pin B. Routing bit 0 moves alarm B from pin A to pin B. Routing bit 1 moves the periodic interrupt from pin A to pin B.
- R10: Each pin is the wired-AND of its sources. It is low when any routed flag is set, when a routed periodic input is low, or, on pin B, when the clock input is low.
- R11: While the oscillator-halt input is high, the enables, the flags and the routing field return to 0 on the next edge. The stored alarm minute, hour and mask values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_halt | input | 1 | Oscillator-halt indication from the timekeeper |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write byte |
| min_tick | input | 1 | One-cycle strobe at minute rollover (seconds = 00) |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| per_irq_n | input | 1 | Periodic interrupt, active low |
| clk32k | input | 1 | 32 kHz clock level to route |
| pin_a_n | output | 1 | Interrupt pin A, active low |
| pin_b_n | output | 1 | Interrupt pin B, active low |
| flag_a | output | 1 | Alarm A match flag |
| flag_b | output | 1 | Alarm B match flag |

## Verification
The functions that can collide are an alarm match on the minute strobe and a host control write that clears the same flag, or disables the same alarm. The bench provokes each collision by raising the strobe with a matching time in the same cycle as a control write of a zero flag bit. It then repeats this with the enable bit also zero. The result is judged from the flag one cycle later: set in the first case and clear in the second. The routing sweep also crosses every flag state with every level of the periodic and clock inputs, so that routed sources overlapping on one pin are checked against the wired-AND.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int WDAY_W = 3;
  localparam int DAYS   = 7;
  localparam int NALM   = 2;
  localparam int AW     = 3;
  localparam int DW     = 8;
  localparam int REGS_PER_ALM = 3;
  localparam int EN_LSB    = 0;
  localparam int FLAG_LSB  = NALM;
  localparam int ROUTE_LSB = 2 * NALM;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(REGS_PER_ALM * NALM);

  typedef enum logic [1:0] {
    RT_ALL_A      = 2'b00,
    RT_B_TO_PINB  = 2'b01,
    RT_P_TO_PINB  = 2'b10,
    RT_BP_TO_PINB = 2'b11
  } route_e;

  typedef struct packed {
    logic [MIN_W-1:0]  mins;
    logic [HOUR_W-1:0] hrs;
    logic [DAYS-1:0]   days;
  } alarm_cfg_t;

  typedef struct packed {
    logic a_n;
    logic b_n;
  } pins_t;

  function automatic logic day_selected(logic [DAYS-1:0] mask, logic [WDAY_W-1:0] wd);
    logic sel;
    sel = 1'b0;
    for (int i = 0; i < DAYS; i++) begin
      if (wd == WDAY_W'(i) && mask[i]) sel = 1'b1;
    end
    return sel;
  endfunction

  function automatic logic time_equal(alarm_cfg_t c, logic [MIN_W-1:0] m, logic [HOUR_W-1:0] h);
    return (c.mins == m) && (c.hrs == h);
  endfunction

  function automatic pins_t route_pins(route_e rt, logic alm_a, logic alm_b,
                                       logic per_n, logic clk_lvl);
    logic [1:0] r;
    logic low_a, low_b;
    pins_t p;
    r     = rt;
    low_a = alm_a | (alm_b & ~r[0]) | (~per_n & ~r[1]);
    low_b = ~clk_lvl | (alm_b & r[0]) | (~per_n & r[1]);
    p.a_n = ~low_a;
    p.b_n = ~low_b;
    return p;
  endfunction
endpackage

// File: rtl/alm_cfg_regs.sv
module alm_cfg_regs
  import alm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  osc_halt,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  output alarm_cfg_t [NALM-1:0] cfg,
  output logic [NALM-1:0]       en_q,
  output logic [NALM-1:0]       en_next,
  output logic [NALM-1:0]       clr_req,
  output route_e                route_q
);
  logic ctrl_wr;
  logic unused_hi_bits;

  assign ctrl_wr        = wr_en && (wr_addr == CTRL_ADDR);
  assign unused_hi_bits = ^wr_data[DW-1:ROUTE_LSB+2];

  always_comb begin
    if (osc_halt)     en_next = '0;
    else if (ctrl_wr) en_next = wr_data[EN_LSB +: NALM];
    else              en_next = en_q;
    clr_req = ctrl_wr ? ~wr_data[FLAG_LSB +: NALM] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= RT_ALL_A;
    end else begin
      en_q <= en_next;
      if (osc_halt)     route_q <= RT_ALL_A;
      else if (ctrl_wr) route_q <= route_e'(wr_data[ROUTE_LSB +: 2]);
    end
  end

  for (genvar k = 0; k < NALM; k++) begin : g_alm_regs
    localparam logic [AW-1:0] BASE = AW'(REGS_PER_ALM * k);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[k] <= '0;
      end else if (wr_en) begin
        if (wr_addr == BASE)            cfg[k].mins <= wr_data[MIN_W-1:0];
        if (wr_addr == BASE + AW'(1))   cfg[k].hrs  <= wr_data[HOUR_W-1:0];
        if (wr_addr == BASE + AW'(2))   cfg[k].days <= wr_data[DAYS-1:0];
      end
    end
  end
endmodule

// File: rtl/alm_channel.sv
module alm_channel
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              min_tick,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  alarm_cfg_t        cfg,
  input  logic              en_q,
  input  logic              en_next,
  input  logic              clr_req,
  output logic              hit,
  output logic              flag_q
);
  logic same_time;
  logic day_ok;

  assign same_time = time_equal(cfg, cur_min, cur_hour);
  assign day_ok    = day_selected(cfg.days, cur_wday);
  assign hit       = min_tick & en_q & same_time & day_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= en_next & (hit | (flag_q & ~clr_req));
  end
endmodule

// File: rtl/alm_pin_mux.sv
module alm_pin_mux
  import alm_pkg::*;
(
  input  route_e          route,
  input  logic [NALM-1:0] flags,
  input  logic            per_irq_n,
  input  logic            clk32k,
  output logic            pin_a_n,
  output logic            pin_b_n
);
  pins_t p;
  assign p       = route_pins(route, flags[0], flags[1], per_irq_n, clk32k);
  assign pin_a_n = p.a_n;
  assign pin_b_n = p.b_n;
endmodule

// File: rtl/alm_dual_cmp.sv
module alm_dual_cmp
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_halt,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              min_tick,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              per_irq_n,
  input  logic              clk32k,
  output logic              pin_a_n,
  output logic              pin_b_n,
  output logic              flag_a,
  output logic              flag_b
);
  alarm_cfg_t [NALM-1:0] cfg;
  logic [NALM-1:0]       en_vec;
  logic [NALM-1:0]       en_next;
  logic [NALM-1:0]       clr_req;
  logic [NALM-1:0]       hit_vec;
  logic [NALM-1:0]       flag_vec;
  route_e                route_q;

  alm_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .osc_halt(osc_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .en_q(en_vec), .en_next(en_next),
    .clr_req(clr_req), .route_q(route_q)
  );

  for (genvar k = 0; k < NALM; k++) begin : g_chan
    alm_channel u_chan (
      .clk(clk), .rst_n(rst_n), .min_tick(min_tick),
      .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
      .cfg(cfg[k]), .en_q(en_vec[k]), .en_next(en_next[k]),
      .clr_req(clr_req[k]), .hit(hit_vec[k]), .flag_q(flag_vec[k])
    );
  end

  alm_pin_mux u_mux (
    .route(route_q), .flags(flag_vec), .per_irq_n(per_irq_n),
    .clk32k(clk32k), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n)
  );

  assign flag_a = flag_vec[0];
  assign flag_b = flag_vec[1];
endmodule

// File: rtl/alm_dual_cmp_chk.sv
module alm_dual_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_halt,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [1:0] wr_en_bits,
  input logic       min_tick,
  input logic       clk32k,
  input logic       pin_a_n,
  input logic       pin_b_n,
  input logic       flag_a,
  input logic       flag_b,
  input logic [1:0] hit_vec,
  input logic [1:0] en_vec,
  input logic [1:0] route_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == 3'd6);

  AST_A_SETS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] && !osc_halt && !(ctrl_wr && !wr_en_bits[0]) |=> flag_a); // R3
  AST_B_SETS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[1] && !osc_halt && !(ctrl_wr && !wr_en_bits[1]) |=> flag_b); // R3
  AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != 2'b00) |-> min_tick); // R5
  AST_NO_SPURIOUS_A: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_a && !hit_vec[0] |=> !flag_a); // R5
  AST_NO_SPURIOUS_B: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_b && !hit_vec[1] |=> !flag_b); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_a && !osc_halt && !ctrl_wr |=> flag_a); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wr_en_bits[0] |=> !flag_a); // R7
  AST_HALT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    osc_halt |=> (en_vec == 2'b00) && (route_q == 2'b00) && !flag_a && !flag_b); // R11
  AST_PIN_A_CARRIES_A: assert property (@(posedge clk) disable iff (!rst_n)
    flag_a |-> !pin_a_n); // R9
  AST_CLK_ON_PIN_B: assert property (@(posedge clk) disable iff (!rst_n)
    !clk32k |-> !pin_b_n); // R10
endmodule

bind alm_dual_cmp alm_dual_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_halt(osc_halt), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_en_bits(wr_data[1:0]), .min_tick(min_tick),
  .clk32k(clk32k), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n),
  .flag_a(flag_a), .flag_b(flag_b), .hit_vec(hit_vec),
  .en_vec(en_vec), .route_q(route_q)
);

// File: tb/alm_dual_cmp_bench.sv
module alm_dual_cmp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_halt = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       min_tick = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       per_irq_n = 1'b1;
  logic       clk32k = 1'b1;
  logic       pin_a_n, pin_b_n, flag_a, flag_b;

  int n_chk = 0;
  int n_err = 0;
  bit reported = 1'b0;

  localparam logic [6:0] MASK_A = 7'b0101011;

  always #5 clk = ~clk;

  alm_dual_cmp u_alm_dual_cmp (
    .clk(clk), .rst_n(rst_n), .osc_halt(osc_halt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .min_tick(min_tick),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .per_irq_n(per_irq_n), .clk32k(clk32k), .pin_a_n(pin_a_n),
    .pin_b_n(pin_b_n), .flag_a(flag_a), .flag_b(flag_b)
  );

  function automatic logic [6:0] to_bcd(int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(logic [6:0] m, logic [5:0] h, logic [2:0] wd);
    @(negedge clk);
    cur_min = m; cur_hour = h; cur_wday = wd; min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
  endtask

  task automatic tick_with_ctrl(logic [6:0] m, logic [5:0] h, logic [2:0] wd, logic [7:0] d);
    @(negedge clk);
    cur_min = m; cur_hour = h; cur_wday = wd; min_tick = 1'b1;
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = d;
    @(negedge clk);
    min_tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag_a", {7'd0, flag_a}, 8'd0);
    chk("R1 flag_b", {7'd0, flag_b}, 8'd0);
    chk("R1 pins", {6'd0, pin_a_n, pin_b_n}, 8'h03);

    // R2 register map: A at 12:30 mask, B at 07:45 every day
    wr(3'd0, 8'h30); wr(3'd1, 8'h12); wr(3'd2, {1'b0, MASK_A});
    wr(3'd3, 8'h45); wr(3'd4, 8'h07); wr(3'd5, 8'h7F);
    // R1/R5: enables still 0 after reset, a matching strobe does nothing
    tick(7'h30, 6'h12, 3'd1);
    chk("R1 disabled after reset", {7'd0, flag_a}, 8'd0);
    wr(3'd6, 8'h03);

    // R3 minute sweep
    for (int m = 0; m < 60; m++) begin
      tick(to_bcd(m), 6'h12, 3'd1);
      chk("R3 minute sweep", {7'd0, flag_a}, (m == 30) ? 8'd1 : 8'd0);
      if (flag_a) wr(3'd6, 8'h03);
    end
    // R3 hour sweep
    for (int h = 0; h < 24; h++) begin
      tick(7'h30, 6'(to_bcd(h)), 3'd0);
      chk("R3 hour sweep", {7'd0, flag_a}, (h == 12) ? 8'd1 : 8'd0);
      if (flag_a) wr(3'd6, 8'h03);
    end
    // R4 weekday sweep including invalid 7
    for (int wd = 0; wd < 8; wd++) begin
      tick(7'h30, 6'h12, 3'(wd));
      chk("R4 weekday A", {7'd0, flag_a}, (wd < 7 && MASK_A[wd]) ? 8'd1 : 8'd0);
      if (flag_a) wr(3'd6, 8'h03);
    end
    for (int wd = 0; wd < 7; wd++) begin
      tick(7'h45, 6'h07, 3'(wd));
      chk("R4 weekday B", {6'd0, flag_b, flag_a}, 8'h02);
      wr(3'd6, 8'h03);
    end

    // R5 no strobe, matching time held
    @(negedge clk);
    cur_min = 7'h30; cur_hour = 6'h12; cur_wday = 3'd1;
    repeat (5) @(negedge clk);
    chk("R5 no strobe", {7'd0, flag_a}, 8'd0);

    // R6 sticky
    tick(7'h30, 6'h12, 3'd1);
    repeat (8) @(negedge clk);
    chk("R6 sticky", {6'd0, pin_a_n, flag_a}, 8'h01);
    wr(3'd6, 8'h07);
    chk("R6 write 1 keeps", {7'd0, flag_a}, 8'd1);
    wr(3'd6, 8'h03);
    chk("R6 write 0 clears", {7'd0, flag_a}, 8'd0);

    // R7 disable clears and blocks
    tick(7'h30, 6'h12, 3'd1);
    wr(3'd6, 8'h06);
    chk("R7 disable clears", {7'd0, flag_a}, 8'd0);
    tick(7'h30, 6'h12, 3'd1);
    chk("R7 disabled ignores", {7'd0, flag_a}, 8'd0);
    wr(3'd6, 8'h03);

    // R8 collisions
    tick(7'h30, 6'h12, 3'd1);
    tick_with_ctrl(7'h30, 6'h12, 3'd1, 8'h03);
    chk("R8 match beats clear", {7'd0, flag_a}, 8'd1);
    tick_with_ctrl(7'h30, 6'h12, 3'd1, 8'h06);
    chk("R8 disable beats match", {7'd0, flag_a}, 8'd0);
    wr(3'd6, 8'h03);

    // R11 halt restores defaults, keeps alarm times
    wr(3'd6, 8'h33);
    tick(7'h30, 6'h12, 3'd1);
    tick(7'h45, 6'h07, 3'd1);
    chk("R11 pre halt", {6'd0, flag_b, flag_a}, 8'h03);
    @(negedge clk); osc_halt = 1'b1;
    @(negedge clk); osc_halt = 1'b0;
    chk("R11 flags cleared", {6'd0, flag_b, flag_a}, 8'h00);
    tick(7'h30, 6'h12, 3'd1);
    chk("R11 enables cleared", {7'd0, flag_a}, 8'd0);
    wr(3'd6, 8'h03);
    tick(7'h45, 6'h07, 3'd1);
    chk("R11 route back to 00 (B on pin A)", {6'd0, pin_a_n, pin_b_n}, 8'h01);
    tick(7'h30, 6'h12, 3'd1);
    chk("R11 times kept", {7'd0, flag_a}, 8'd1);

    // R9/R10 routing and wired-AND sweep
    for (int r = 0; r < 4; r++) begin
      for (int fa = 0; fa < 2; fa++) begin
        for (int fb = 0; fb < 2; fb++) begin
          wr(3'd6, 8'(r << 4) | 8'h0F);
          tick(7'h30, 6'h12, 3'd1);
          tick(7'h45, 6'h07, 3'd1);
          wr(3'd6, 8'(r << 4) | 8'(fb << 3) | 8'(fa << 2) | 8'h03);
          for (int pv = 0; pv < 2; pv++) begin
            for (int cv = 0; cv < 2; cv++) begin
              logic ea, eb;
              @(negedge clk);
              per_irq_n = 1'(pv); clk32k = 1'(cv);
              @(negedge clk);
              ea = !((fa == 1) || (fb == 1 && r[0] == 1'b0) || (pv == 0 && r[1] == 1'b0));
              eb = (cv == 1) && !((fb == 1 && r[0] == 1'b1) || (pv == 0 && r[1] == 1'b1));
              chk("R9 R10 pin A", {7'd0, pin_a_n}, {7'd0, ea});
              chk("R9 R10 pin B", {7'd0, pin_b_n}, {7'd0, eb});
            end
          end
          per_irq_n = 1'b1; clk32k = 1'b1;
        end
      end
    end
    report();
  end
endmodule